// File: doc/BRIEF.md
# Banked GPIO and Pin-Function Controller

This block owns the pads of a chip: up to 56 of them, grouped in banks of sixteen. The last bank holds only eight pins. Software reaches the block through a plain 32-bit register port addressed in bytes. For every pin the block stores these settings: an output level, a direction, a two-bit function select, an open-drain enable, a pull enable and a pull polarity. It also returns the pad's level after a two-stage synchronizer.

The function select picks the pad's driver. Code 0 hands the pad to the GPIO logic. Codes 1 to 3 hand it to one of three on-chip peripheral sources, and those sources supply their own output value and output enable. Pull requests go out to the pad cell as separate pull-up and pull-down lines.

The parameter `NUM_PINS` sets the build: 32 pins (the default, two banks) or 56 pins (four banks). Register writes take effect on the next clock edge. Read data is a combinational function of the address.

Top module: `gpmx_ctrl`

## Requirements
- R1: After reset every stored setting is 0, so every readable register returns 0 and `pad_oe`, `pad_out`, `pad_pull_up` and `pad_pull_dn` are all 0.
- R2: Bank b (b = pin/16) occupies byte addresses b*0x30 + offset. The offsets are: output 0x00, input 0x04, direction 0x08, select-low 0x0C, select-high 0x10, open-drain 0x14, pull polarity 0x1C, pull enable 0x20. A pin's setting is bit pin%16 of data bits [15:0], and bits [31:16] read 0.
- R3: In the 56-pin build, bank 3 keeps its output, input, direction and select-low registers at 0x90 + offset. Its open-drain register is at 0x24, its pull polarity at 0x28, its pull enable at 0x2C and its select-high at 0x54. Its own stride offsets 0xA0, 0xA4, 0xAC and 0xB0 are unmapped.
- R4: Bits for pins that do not exist (bank 3 bits 15:8) read 0, and writes to them are dropped.
- R5: The input register returns the pad level as sampled at the second rising edge after it changes, through two flops. Writes to the input register change nothing.
- R6: When a pin is in GPIO mode (select 0) without open-drain, `pad_oe` equals the direction bit (1 = output) and `pad_out` equals the output bit.
- R7: When a pin is in GPIO mode with open-drain set, `pad_out` is 0. `pad_oe` is 1 only when direction is 1 and the output bit is 0; an output bit of 1 releases the pad.
- R8: The function select is {select-high bit, select-low bit}. A value k of 1 to 3 drives the pad from `alt_out[(k-1)*NUM_PINS+pin]` and `alt_oe[(k-1)*NUM_PINS+pin]`, whatever the direction, output and open-drain bits hold.
- R9: `pad_pull_up` is pull-enable AND polarity; `pad_pull_dn` is pull-enable AND NOT polarity. With pull-enable 0, neither line is asserted.
- R10: Reads of unmapped or unaligned addresses return 0, and writes to them change no setting.
- R11: A write with `wr_en` high is visible in the read data and on the pad outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pad_in | input | NUM_PINS | Raw pad levels, asynchronous |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_up | output | NUM_PINS | Pull-up request |
| pad_pull_dn | output | NUM_PINS | Pull-down request |
| alt_out | input | 3*NUM_PINS | Output values of functions 1 to 3, one slice per function |
| alt_oe | input | 3*NUM_PINS | Output enables of functions 1 to 3 |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are stable around each rising edge and carry no X after reset. They make no assumption about `pad_in`, `alt_out` or `alt_oe`, which may change at any time. The bench changes every input one time unit after a rising edge and compares at the falling edge. Its random phase covers aligned and unaligned addresses over the whole 0x00 to 0xBF window, so mapped, remapped and unmapped offsets all occur together with arbitrary pad and function inputs.

// File: rtl/gpmx_pkg.sv
package gpmx_pkg;

  localparam int BANK_PINS   = 16;
  localparam int BANK_STRIDE = 'h30;
  localparam int NUM_KINDS   = 8;
  localparam int NUM_ALT     = 3;

  typedef enum logic [2:0] {
    RK_DOUT   = 3'd0,
    RK_DIN    = 3'd1,
    RK_DIR    = 3'd2,
    RK_FSEL0  = 3'd3,
    RK_FSEL1  = 3'd4,
    RK_ODRAIN = 3'd5,
    RK_PSEL   = 3'd6,
    RK_PEN    = 3'd7
  } reg_kind_e;

  // Byte address of a register kind for a given bank; the short last bank
  // keeps some of its registers in spare slots of the first two banks.
  function automatic int reg_addr(reg_kind_e kind, int bank);
    int off;
    case (kind)
      RK_DOUT:   off = 'h00;
      RK_DIN:    off = 'h04;
      RK_DIR:    off = 'h08;
      RK_FSEL0:  off = 'h0C;
      RK_FSEL1:  off = 'h10;
      RK_ODRAIN: off = 'h14;
      RK_PSEL:   off = 'h1C;
      default:   off = 'h20;
    endcase
    if (bank == 3) begin
      case (kind)
        RK_FSEL1:  return BANK_STRIDE + 'h24;
        RK_ODRAIN: return 'h24;
        RK_PSEL:   return 'h28;
        RK_PEN:    return 'h2C;
        default:   ;
      endcase
    end
    return bank * BANK_STRIDE + off;
  endfunction

endpackage

// File: rtl/gpmx_sync.sv
module gpmx_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpmx_regfile.sv
module gpmx_regfile
  import gpmx_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] din_sync,
  output logic [31:0]         rdata,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] fsel0_q,
  output logic [NUM_PINS-1:0] fsel1_q,
  output logic [NUM_PINS-1:0] odrain_q,
  output logic [NUM_PINS-1:0] psel_q,
  output logic [NUM_PINS-1:0] pen_q
);

  logic [NUM_PINS-1:0] store_q [NUM_KINDS];
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:BANK_PINS];

  // Each pin bit compares the bus address with its own register address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_KINDS; k++) store_q[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (k != int'(RK_DIN)) begin
          for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(addr) == reg_addr(reg_kind_e'(k), p / BANK_PINS))
              store_q[k][p] <= wdata[p % BANK_PINS];
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (int'(addr) == reg_addr(reg_kind_e'(k), p / BANK_PINS))
          rdata[p % BANK_PINS] = (k == int'(RK_DIN)) ? din_sync[p] : store_q[k][p];
      end
    end
  end

  assign dout_q   = store_q[RK_DOUT];
  assign dir_q    = store_q[RK_DIR];
  assign fsel0_q  = store_q[RK_FSEL0];
  assign fsel1_q  = store_q[RK_FSEL1];
  assign odrain_q = store_q[RK_ODRAIN];
  assign psel_q   = store_q[RK_PSEL];
  assign pen_q    = store_q[RK_PEN];

endmodule

// File: rtl/gpmx_padmux.sv
module gpmx_padmux
  import gpmx_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]         dout_q,
  input  logic [NUM_PINS-1:0]         dir_q,
  input  logic [NUM_PINS-1:0]         fsel0_q,
  input  logic [NUM_PINS-1:0]         fsel1_q,
  input  logic [NUM_PINS-1:0]         odrain_q,
  input  logic [NUM_PINS-1:0]         psel_q,
  input  logic [NUM_PINS-1:0]         pen_q,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [NUM_PINS-1:0]         pad_pull_up,
  output logic [NUM_PINS-1:0]         pad_pull_dn
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] sel;
    logic       po;
    logic       oe;

    assign sel = {fsel1_q[p], fsel0_q[p]};

    always_comb begin
      if (sel == 2'd0) begin
        if (odrain_q[p]) begin
          po = 1'b0;
          oe = dir_q[p] & ~dout_q[p];
        end else begin
          po = dout_q[p];
          oe = dir_q[p];
        end
      end else begin
        po = alt_out[(int'(sel) - 1) * NUM_PINS + p];
        oe = alt_oe[(int'(sel) - 1) * NUM_PINS + p];
      end
    end

    assign pad_out[p]     = po;
    assign pad_oe[p]      = oe;
    assign pad_pull_up[p] = pen_q[p] & psel_q[p];
    assign pad_pull_dn[p] = pen_q[p] & ~psel_q[p];
  end

endmodule

// File: rtl/gpmx_ctrl.sv
module gpmx_ctrl
  import gpmx_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic [NUM_PINS-1:0]         pad_in,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [NUM_PINS-1:0]         pad_pull_up,
  output logic [NUM_PINS-1:0]         pad_pull_dn,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe
);

  logic [NUM_PINS-1:0] din_sync;
  logic [NUM_PINS-1:0] dout_q, dir_q, fsel0_q, fsel1_q, odrain_q, psel_q, pen_q;

  gpmx_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (din_sync)
  );

  gpmx_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .din_sync (din_sync),
    .rdata    (rdata),
    .dout_q   (dout_q),
    .dir_q    (dir_q),
    .fsel0_q  (fsel0_q),
    .fsel1_q  (fsel1_q),
    .odrain_q (odrain_q),
    .psel_q   (psel_q),
    .pen_q    (pen_q)
  );

  gpmx_padmux #(.NUM_PINS(NUM_PINS)) u_pads (
    .dout_q      (dout_q),
    .dir_q       (dir_q),
    .fsel0_q     (fsel0_q),
    .fsel1_q     (fsel1_q),
    .odrain_q    (odrain_q),
    .psel_q      (psel_q),
    .pen_q       (pen_q),
    .alt_out     (alt_out),
    .alt_oe      (alt_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_up (pad_pull_up),
    .pad_pull_dn (pad_pull_dn)
  );

endmodule

// File: rtl/gpmx_ctrl_chk.sv
module gpmx_ctrl_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_pull_up,
  input logic [NUM_PINS-1:0]   pad_pull_dn,
  input logic [3*NUM_PINS-1:0] alt_oe,
  input logic [NUM_PINS-1:0]   dout_q,
  input logic [NUM_PINS-1:0]   dir_q,
  input logic [NUM_PINS-1:0]   fsel0_q,
  input logic [NUM_PINS-1:0]   fsel1_q,
  input logic [NUM_PINS-1:0]   odrain_q
);

  p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0);

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fsel0_q & ~fsel1_q & odrain_q) & pad_oe & pad_out) == '0);

  p_input_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fsel0_q & ~fsel1_q & ~dir_q) & pad_oe) == '0);

  p_alt1_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsel0_q & ~fsel1_q) & (pad_oe ^ alt_oe[NUM_PINS-1:0])) == '0);

  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> (dout_q[15:0] == $past(wdata[15:0])));

  p_unaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rdata == '0));

endmodule

bind gpmx_ctrl gpmx_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .alt_oe      (alt_oe),
  .dout_q      (dout_q),
  .dir_q       (dir_q),
  .fsel0_q     (fsel0_q),
  .fsel1_q     (fsel1_q),
  .odrain_q    (odrain_q)
);

// File: tb/gpmx_ctrl_tb.sv
module gpmx_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 56;
  localparam int AW = 8;
  localparam int NB = (NP + 15) / 16;
  localparam int K_OUT = 0, K_IN = 1, K_DIR = 2, K_A0 = 3, K_A1 = 4,
                 K_OD = 5, K_PS = 6, K_PE = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_pull_up, pad_pull_dn;
  logic [3*NP-1:0] alt_out = '0;
  logic [3*NP-1:0] alt_oe = '0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [NP-1:0] m_reg [8];
  logic [NP-1:0] m_s1 = '0;
  logic [NP-1:0] m_s2 = '0;

  gpmx_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int k = 0; k < 8; k++) m_reg[k] = '0;

  // Address map from the requirements: kind and bank, or kind -1.
  function automatic void decode(input int a, output int kind, output int bank);
    int off;
    kind = -1;
    bank = 0;
    if (a % 4 != 0) return;
    if (NB == 4 && a == 'h24) begin kind = K_OD; bank = 3; return; end
    if (NB == 4 && a == 'h28) begin kind = K_PS; bank = 3; return; end
    if (NB == 4 && a == 'h2C) begin kind = K_PE; bank = 3; return; end
    if (NB == 4 && a == 'h54) begin kind = K_A1; bank = 3; return; end
    if (a / 48 >= NB) return;
    bank = a / 48;
    off = a % 48;
    case (off)
      'h00: kind = K_OUT;
      'h04: kind = K_IN;
      'h08: kind = K_DIR;
      'h0C: kind = K_A0;
      'h10: kind = K_A1;
      'h14: kind = K_OD;
      'h1C: kind = K_PS;
      'h20: kind = K_PE;
      default: kind = -1;
    endcase
    if (bank == 3 && (kind == K_A1 || kind == K_OD || kind == K_PS || kind == K_PE))
      kind = -1;
  endfunction

  function automatic logic [31:0] exp_rdata(input int a);
    int kd, bk;
    logic [31:0] v;
    v = '0;
    decode(a, kd, bk);
    if (kd >= 0) begin
      for (int i = 0; i < 16; i++) begin
        if (bk * 16 + i < NP)
          v[i] = (kd == K_IN) ? m_s2[bk*16+i] : m_reg[kd][bk*16+i];
      end
    end
    return v;
  endfunction

  // Reference model state update.
  always @(posedge clk) begin
    int kd, bk;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_reg[k] = '0;
      m_s1 = '0;
      m_s2 = '0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (wr_en) begin
        decode(int'(addr), kd, bk);
        if (kd >= 0 && kd != K_IN) begin
          for (int i = 0; i < 16; i++)
            if (bk * 16 + i < NP) m_reg[kd][bk*16+i] = wdata[i];
        end
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    int kd, bk, sel;
    string tag;
    logic [31:0] er;
    logic ep, eo, eu, ed;
    if (!done) begin
      er = exp_rdata(int'(addr));
      decode(int'(addr), kd, bk);
      if (kd < 0) tag = "R10";
      else if (kd == K_IN) tag = "R5";
      else if (bk == 3) tag = "R3/R4";
      else tag = "R2";
      compared++;
      if (rdata !== er) begin
        mismatched++;
        $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, addr, rdata, er);
      end
      for (int p = 0; p < NP; p++) begin
        sel = {m_reg[K_A1][p], m_reg[K_A0][p]};
        if (sel != 0) begin
          ep = alt_out[(sel-1)*NP+p];
          eo = alt_oe[(sel-1)*NP+p];
          tag = "R8";
        end else if (m_reg[K_OD][p]) begin
          ep = 1'b0;
          eo = m_reg[K_DIR][p] & ~m_reg[K_OUT][p];
          tag = "R7";
        end else begin
          ep = m_reg[K_OUT][p];
          eo = m_reg[K_DIR][p];
          tag = "R6";
        end
        eu = m_reg[K_PE][p] & m_reg[K_PS][p];
        ed = m_reg[K_PE][p] & ~m_reg[K_PS][p];
        compared++;
        if (pad_out[p] !== ep || pad_oe[p] !== eo) begin
          mismatched++;
          $display("FAIL %s pin %0d out/oe actual=%b%b expected=%b%b",
                   tag, p, pad_out[p], pad_oe[p], ep, eo);
        end
        compared++;
        if (pad_pull_up[p] !== eu || pad_pull_dn[p] !== ed) begin
          mismatched++;
          $display("FAIL R9 pin %0d up/dn actual=%b%b expected=%b%b",
                   p, pad_pull_up[p], pad_pull_dn[p], eu, ed);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic write(input int a, input logic [31:0] d);
    cyc();
    wr_en = 1'b1;
    addr = AW'(a);
    wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s directed actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) cyc();
    @(negedge clk);
    chk("R1", 64'(pad_oe), 64'd0);
    chk("R1", 64'(pad_out | pad_pull_up | pad_pull_dn), 64'd0);
    chk("R1", 64'(rdata), 64'd0);
    cyc();
    rst_n = 1'b1;

    // R11 / R2: write lands after the sampling edge
    write('h00, 32'hFFFF_A5A5);
    @(negedge clk); chk("R11", 64'(rdata), 64'h0000_A5A5);
    write('h38, 32'h0000_1234);
    @(negedge clk); chk("R2", 64'(rdata), 64'h1234);

    // R4: short bank keeps only eight bits
    write('h90, 32'h0000_FFFF);
    @(negedge clk); chk("R4", 64'(rdata), 64'h00FF);

    // R3: remapped slots and dead stride slots of bank 3
    write('h24, 32'h0000_FFFF);
    @(negedge clk); chk("R3", 64'(rdata), 64'h00FF);
    write('hA4, 32'h0000_FFFF);
    @(negedge clk); chk("R3", 64'(rdata), 64'h0);
    write('h54, 32'h0000_0003);
    @(negedge clk); chk("R3", 64'(rdata), 64'h3);
    write('h54, 32'h0000_0000);

    // R10: unmapped and unaligned
    write('hBC, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10", 64'(rdata), 64'h0);
    write('h02, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10", 64'(rdata), 64'h0);

    // R6 / R7: bank 0 mixes open-drain and push-pull pins
    write('h00, 32'h0000_0FF0);
    write('h08, 32'h0000_FFFF);
    write('h14, 32'h0000_00FF);
    @(negedge clk);
    chk("R7", 64'(pad_oe[15:0]), 64'hFF0F);
    chk("R6", 64'(pad_out[15:0]), 64'h0F00);

    // R8: pin 0 -> function 1, pin 1 -> function 2
    cyc();
    alt_out[0] = 1'b1; alt_oe[0] = 1'b1;
    alt_out[NP+1] = 1'b1; alt_oe[NP+1] = 1'b0;
    write('h0C, 32'h0000_0001);
    write('h10, 32'h0000_0002);
    @(negedge clk);
    chk("R8", 64'(pad_out[1:0]), 64'b11);
    chk("R8", 64'(pad_oe[1:0]), 64'b01);

    // R9: pull enable and polarity
    write('h20, 32'h0000_0003);
    write('h1C, 32'h0000_0001);
    @(negedge clk);
    chk("R9", 64'(pad_pull_up[1:0]), 64'b01);
    chk("R9", 64'(pad_pull_dn[1:0]), 64'b10);

    // R5: two-edge input latency, writes to the input ignored
    cyc();
    addr = AW'('h04);
    pad_in = NP'(56'h00_0000_0000_C3A5);
    @(negedge clk); chk("R5", 64'(rdata), 64'h0);
    cyc();
    @(negedge clk); chk("R5", 64'(rdata), 64'h0);
    cyc();
    @(negedge clk); chk("R5", 64'(rdata), 64'hC3A5);
    write('h04, 32'h0000_0000);
    @(negedge clk); chk("R5", 64'(rdata), 64'hC3A5);

    // Random phase checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      cyc();
      wr_en = 1'($urandom % 2);
      addr = AW'($urandom % 'hC0);
      if ($urandom % 8 != 0) addr[1:0] = 2'b00;
      wdata = $urandom;
      for (int b = 0; b < NP; b++) pad_in[b] = 1'($urandom % 2);
      if (n % 16 == 0) begin
        for (int b = 0; b < 3*NP; b++) begin
          alt_out[b] = 1'($urandom % 2);
          alt_oe[b] = 1'($urandom % 2);
        end
      end
    end
    cyc();
    wr_en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule